// File: doc/BRIEF.md
# Cache Block Fetch Controller with Selectable Memory Organisation

This block fetches one four-word (16-byte) cache block from main memory across a clocked bus. It reports how many bus cycles the fetch took. The memory organisation is fixed at elaboration by a parameter, and there are three choices:

- **Narrow:** one memory word wide, so the block is read word by word.
- **Wide:** four words wide, so one access returns the whole block and the bus carries it in one transfer.
- **Banked:** four interleaved banks are accessed together, and their words are then sent one per cycle.

Each organisation overlaps access latency and transfer time in its own way. With the default latency the fetch penalties come out at 65, 17 and 20 bus cycles.

A miss handler raises `req_valid` for one cycle while the block is idle, together with any byte address inside the wanted block. The controller spends that cycle sending the address. It then runs the bank latency models and returns the block with a strobe per transfer and a flag on the final one. The memory contents are modelled inside the banks: the word stored at byte address A reads as A XOR `PATTERN`. The response width is one word for the narrow and banked organisations and four words for the wide one, because that bus is four words wide.

Top module: `fetch_ctrl`

## Requirements

Cycle offsets are counted from the acceptance cycle, which is offset 0. A request is accepted in a cycle where `req_valid` is high and `busy` is low. That cycle is also the address cycle. Each memory access lasts `ACC_LAT` = 15 cycles.

- R1: During and right after a synchronous reset, `busy`, `rsp_valid` and `rsp_last` are 0 and `penalty` is 0.
- R2: After each fetch, `penalty` holds the fetch length in cycles, counted from the address cycle through the final transfer, inclusive. The value is 65 for narrow, 17 for wide and 20 for banked. It keeps this value until the next fetch finishes.
- R3: In the narrow organisation, four single-word transfers appear at offsets 16, 32, 48 and 64. `rsp_valid` is low between them.
- R4: In the wide organisation, a single transfer appears at offset 16. Lane i, at bits [32i+31:32i] of `rsp_data`, carries word i of the block.
- R5: In the banked organisation, four single-word transfers appear at offsets 16, 17, 18 and 19, back to back.
- R6: Words are delivered in ascending address order. The word at byte address A has the value A XOR `PATTERN`, where `PATTERN` defaults to 32'hC0DE0000.
- R7: Bits [3:0] of `req_addr` are ignored. The fetched block starts at `req_addr` with those bits cleared.
- R8: A `req_valid` pulse while `busy` is high has no effect. It causes no extra transfers, does not change the returned data, and does not change `penalty`.
- R9: `busy` is high from offset 1 through the final transfer and low in the cycle after it. A new request is accepted in that cycle.
- R10: `rsp_last` is high on the final transfer of a block and on no other cycle.
- R11: In the banked organisation, bank i serves only words whose address bits [3:2] equal i.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Block fetch request, taken only when idle |
| req_addr | input | ADDR_W | Byte address within the wanted block |
| busy | output | 1 | Fetch in progress |
| rsp_valid | output | 1 | A transfer is on `rsp_data` this cycle |
| rsp_last | output | 1 | Final transfer of the block |
| rsp_data | output | LANES*WORD_W | Returned word(s); LANES is 4 for wide, else 1 |
| penalty | output | PEN_W | Cycle count of the most recent completed fetch |

## Verification

The case that is hardest to reach from the ports is a request that arrives while a fetch is in flight. The controller must drop that request without disturbing the block being returned or the recorded penalty.

The bench produces this case by raising a second request with a different address a few cycles into a fetch. At that point all three organisations are still busy. The scoreboard then rejects any extra or altered transfer, and the penalty is compared again afterwards.

Back-to-back acceptance is reached by issuing the next request in the very cycle `busy` drops. A further request uses the topmost block of the address space to exercise address wrap at the block boundary.

// File: rtl/fetch_pkg.sv
// Shared types for the block fetch controller.
// Assumes a block is a power-of-two number of 32-bit-aligned words.
package fetch_pkg;

    // Memory organisation chosen at elaboration time
    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_WIDE   = 2'd1,
        ORG_BANKED = 2'd2
    } org_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_XFER   = 2'd2
    } seq_state_e;

    // Expected fetch length in bus cycles for an organisation
    function automatic int unsigned penalty_of(org_e org, int unsigned words,
                                               int unsigned lat);
        case (org)
            ORG_NARROW: return 1 + words * (lat + 1);
            ORG_WIDE:   return lat + 2;
            default:    return 1 + lat + words;
        endcase
    endfunction

endpackage

// File: rtl/fetch_bank.sv
// One memory bank timing model.
// A start pulse latches a word address. The bank then counts LAT cycles and
// raises rdy for exactly one cycle, the last cycle of the access, with rdata
// valid in that cycle.
// Contents are modelled: the word at byte address A reads as A ^ PATTERN.
// Assumes start is never pulsed while an access is already running.
module fetch_bank #(
    parameter int              ADDR_W   = 32,
    parameter int              WORD_W   = 32,
    parameter int              LAT      = 15,
    parameter logic [WORD_W-1:0] PATTERN = 32'hC0DE_0000,
    parameter int              BANK_ID  = 0,
    parameter int              SEL_LO   = 2,
    parameter int              SEL_W    = 2,
    parameter bit              CHECK_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              rdy,
    output logic [WORD_W-1:0] rdata
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;

    // Latency countdown: load on start, retire when it reaches zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(LAT - 1);
            addr_q   <= start_addr;
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign rdy   = active_q && (cnt_q == '0);
    assign rdata = WORD_W'(addr_q) ^ PATTERN;

    // R3: a completed access reports ready for a single cycle only
    a_r3_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy) else $error("bank ready held");

    generate
        if (CHECK_ID) begin : g_id_chk
            // R11: an interleaved bank only ever receives its own word slot
            a_r11_bank_lane: assert property (@(posedge clk) disable iff (!rst_n)
                start |-> (start_addr[SEL_LO +: SEL_W] == SEL_W'(BANK_ID)))
                else $error("bank %0d got foreign word", BANK_ID);
        end
    endgenerate

endmodule

// File: rtl/fetch_seq.sv
// Fetch sequencer.
// Accepts a request when idle and starts the bank accesses. Once all banks
// report ready it captures their words, then plays them out in the transfer
// pattern of the chosen organisation.
// Narrow: access then one transfer, repeated per word.
// Wide: one access, one four-lane transfer.
// Banked: one parallel access, then one word per cycle.
// Assumes NBANK and LANES are consistent with ORG (set by the top).
module fetch_seq
    import fetch_pkg::*;
#(
    parameter org_e ORG       = ORG_BANKED,
    parameter int   ADDR_W    = 32,
    parameter int   WORD_W    = 32,
    parameter int   BLK_WORDS = 4,
    parameter int   NBANK     = 4,
    parameter int   LANES     = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    accept,
    output logic                    busy,
    output logic                    bank_start,
    output logic [ADDR_W-1:0]       bank_addr [NBANK],
    input  logic [NBANK-1:0]        bank_rdy,
    input  logic [WORD_W-1:0]       bank_data [NBANK],
    output logic                    rsp_valid,
    output logic                    rsp_last,
    output logic [LANES*WORD_W-1:0] rsp_data
);
    localparam int OFS_W  = $clog2(BLK_WORDS) + 2;
    localparam int BEAT_W = $clog2(BLK_WORDS);
    localparam int NBEATS = (ORG == ORG_WIDE) ? 1 : BLK_WORDS;

    seq_state_e        state_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] buf_q [NBANK];
    logic [ADDR_W-1:0] req_base;
    logic              last_beat;
    logic              capture;
    logic              unused_ofs;

    assign req_base   = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign unused_ofs = ^req_addr[OFS_W-1:0];
    assign accept     = req_valid && (state_q == ST_IDLE);
    assign busy       = (state_q != ST_IDLE);
    assign last_beat  = (beat_q == BEAT_W'(NBEATS - 1));
    assign capture    = (state_q == ST_ACCESS) && (&bank_rdy);
    assign rsp_valid  = (state_q == ST_XFER);
    assign rsp_last   = rsp_valid && last_beat;

    // Main state machine: idle -> access -> transfer (-> access in narrow)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        base_q  <= req_base;
                        beat_q  <= '0;
                        state_q <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (&bank_rdy) state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (last_beat) begin
                        state_q <= ST_IDLE;
                    end else begin
                        beat_q  <= beat_q + BEAT_W'(1);
                        state_q <= (ORG == ORG_NARROW) ? ST_ACCESS : ST_XFER;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Word capture registers, one per bank
    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_buf
            // Hold the bank word once every bank has finished its access
            always_ff @(posedge clk) begin
                if (!rst_n)       buf_q[g] <= '0;
                else if (capture) buf_q[g] <= bank_data[g];
            end
        end
    endgenerate

    // Address issue and data path, per organisation
    generate
        if (ORG == ORG_NARROW) begin : g_narrow
            logic [ADDR_W-1:0] next_ofs;
            assign next_ofs     = ADDR_W'({beat_q + BEAT_W'(1), 2'b00});
            assign bank_start   = accept || (rsp_valid && !last_beat);
            assign bank_addr[0] = accept ? req_base : (base_q + next_ofs);
            assign rsp_data     = buf_q[0];

            // R3: narrow transfers are always separated by a new access
            a_r3_beat_gap: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid |=> !rsp_valid) else $error("narrow beats adjacent");
        end else begin : g_parallel
            assign bank_start = accept;
            for (genvar g = 0; g < NBANK; g++) begin : g_addr
                assign bank_addr[g] = req_base | ADDR_W'(g * 4);
            end
            if (ORG == ORG_WIDE) begin : g_wide
                for (genvar g = 0; g < LANES; g++) begin : g_lane
                    assign rsp_data[g*WORD_W +: WORD_W] = buf_q[g];
                end
                // R4: the wide organisation ends its block in a single transfer
                a_r4_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
                    rsp_valid |-> rsp_last) else $error("wide beat not last");
            end else begin : g_banked
                assign rsp_data = buf_q[beat_q];
                // R5: banked transfers run back to back until the last one
                a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
                    (rsp_valid && !rsp_last) |=> rsp_valid) else $error("banked gap");
            end
        end
    endgenerate

    // R9: an accepted request makes the block busy in the next cycle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy) else $error("not busy after accept");

    // R9: the cycle after the final transfer is idle
    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !busy) else $error("still busy after last");

    // R10: the last flag only travels with a transfer
    a_r10_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid) else $error("last without valid");

    // R8: a request during a fetch leaves the block address alone
    a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(base_q)) else $error("base moved while busy");

endmodule

// File: rtl/fetch_penalty.sv
// Miss penalty counter.
// Starts at 1 in the address cycle and counts every busy cycle after it.
// On the final transfer it latches the inclusive total.
// Assumes accept, busy and last come from the fetch sequencer.
module fetch_penalty #(
    parameter int PEN_W   = 16,
    parameter int EXP_PEN = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             busy,
    input  logic             last,
    output logic [PEN_W-1:0] penalty
);
    logic [PEN_W-1:0] run_q;

    // Running count of cycles since the address cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (accept) run_q <= PEN_W'(1);
        else if (busy)   run_q <= run_q + 1'b1;
    end

    // Latch the inclusive total on the final transfer
    always_ff @(posedge clk) begin
        if (!rst_n)    penalty <= '0;
        else if (last) penalty <= run_q + 1'b1;
    end

    // R2: the recorded penalty matches the organisation's closed form
    a_r2_penalty_exact: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (penalty == PEN_W'(EXP_PEN))) else $error("penalty %0d", penalty);

endmodule

// File: rtl/fetch_ctrl.sv
// Cache block fetch controller (top).
// Connects the sequencer, one bank model per parallel word slot and the
// penalty counter. ORG selects the narrow, wide or banked organisation.
// Assumes WORD_W equals ADDR_W so that modelled contents derive from the
// address.
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter org_e              ORG       = ORG_BANKED,
    parameter int                ADDR_W    = 32,
    parameter int                WORD_W    = 32,
    parameter int                BLK_WORDS = 4,
    parameter int                ACC_LAT   = 15,
    parameter int                PEN_W     = 16,
    parameter logic [WORD_W-1:0] PATTERN   = 32'hC0DE_0000,
    localparam int               LANES     = (ORG == ORG_WIDE) ? BLK_WORDS : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    busy,
    output logic                    rsp_valid,
    output logic                    rsp_last,
    output logic [LANES*WORD_W-1:0] rsp_data,
    output logic [PEN_W-1:0]        penalty
);
    localparam int NBANK   = (ORG == ORG_NARROW) ? 1 : BLK_WORDS;
    localparam int SEL_W   = $clog2(BLK_WORDS);
    localparam int EXP_PEN = int'(penalty_of(ORG, BLK_WORDS, ACC_LAT));

    logic              accept;
    logic              bank_start;
    logic [ADDR_W-1:0] bank_addr [NBANK];
    logic [NBANK-1:0]  bank_rdy;
    logic [WORD_W-1:0] bank_data [NBANK];

    fetch_seq #(
        .ORG(ORG), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
        .BLK_WORDS(BLK_WORDS), .NBANK(NBANK), .LANES(LANES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .accept(accept), .busy(busy),
        .bank_start(bank_start), .bank_addr(bank_addr),
        .bank_rdy(bank_rdy), .bank_data(bank_data),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data)
    );

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            fetch_bank #(
                .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LAT(ACC_LAT),
                .PATTERN(PATTERN), .BANK_ID(g), .SEL_LO(2), .SEL_W(SEL_W),
                .CHECK_ID(ORG == ORG_BANKED)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .start(bank_start), .start_addr(bank_addr[g]),
                .rdy(bank_rdy[g]), .rdata(bank_data[g])
            );
        end
    endgenerate

    fetch_penalty #(.PEN_W(PEN_W), .EXP_PEN(EXP_PEN)) u_pen (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .busy(busy), .last(rsp_last),
        .penalty(penalty)
    );

endmodule

// File: tb/sim_fetch_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: one instance per organisation, all driven by shared stimulus.
module sim_fetch_ctrl;
    import fetch_pkg::*;

    localparam int          LAT = 15;
    localparam logic [31:0] PAT = 32'hC0DE_0000;

    typedef struct {
        int           cyc;
        logic [127:0] data;
        bit           last;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;

    logic        b0, v0, l0, b1, v1, l1, b2, v2, l2;
    logic [31:0]  d0, d1;
    logic [127:0] d2;
    logic [15:0]  p0, p1, p2;

    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];
    bit   pl0 = 0, pl1 = 0, pl2 = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fetch_ctrl #(.ORG(ORG_BANKED)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(b0), .rsp_valid(v0), .rsp_last(l0), .rsp_data(d0), .penalty(p0));
    fetch_ctrl #(.ORG(ORG_NARROW)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(b1), .rsp_valid(v1), .rsp_last(l1), .rsp_data(d1), .penalty(p1));
    fetch_ctrl #(.ORG(ORG_WIDE)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(b2), .rsp_valid(v2), .rsp_last(l2), .rsp_data(d2), .penalty(p2));

    task automatic chk(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Monitor: pop one expected transfer per observed beat and compare it
    task automatic mon(input string tag, ref exp_t qq[$], input logic v,
                       input logic l, input logic b, input logic [127:0] d,
                       ref bit prev_last);
        exp_t e;
        if (prev_last) chk(!b, {tag, " R9 idle after last"}, 128'(b), 128'(0));
        prev_last = v && l;
        if (v) begin
            if (qq.size() == 0) begin
                chk(1'b0, {tag, " R8 unexpected beat"}, 128'(cyc), 128'(0));
            end else begin
                e = qq.pop_front();
                chk(cyc == e.cyc, {tag, " timing"}, 128'(cyc), 128'(e.cyc));
                chk(d == e.data, {tag, " R6 R11 data"}, d, e.data);
                chk(l == e.last, {tag, " R10 last flag"}, 128'(l), 128'(e.last));
                chk(b, {tag, " R9 busy during beat"}, 128'(b), 128'(1));
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mon("u0 R5", q0, v0, l0, b0, {96'd0, d0}, pl0);
            mon("u1 R3", q1, v1, l1, b1, {96'd0, d1}, pl1);
            mon("u2 R4", q2, v2, l2, b2, d2, pl2);
        end
    end

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return a ^ PAT;
    endfunction

    // Driver: issue one request, push expected transfers, wait for completion
    task automatic fetch(input logic [31:0] addr, input bit interfere);
        logic [31:0]  base;
        logic [127:0] blk;
        int           k;
        exp_t         e;
        while (b0 || b1 || b2) @(negedge clk);
        base = {addr[31:4], 4'b0000};   // R7: offset bits dropped
        k    = cyc;
        blk  = '0;
        for (int i = 0; i < 4; i++) begin
            blk[i*32 +: 32] = word_at(base + 32'(i * 4));
            e.cyc = k + LAT + 1 + i;
            e.data = {96'd0, word_at(base + 32'(i * 4))};
            e.last = (i == 3);
            q0.push_back(e);
            e.cyc = k + (LAT + 1) * (i + 1);
            q1.push_back(e);
        end
        e.cyc = k + LAT + 1;
        e.data = blk;
        e.last = 1'b1;
        q2.push_back(e);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(b0 && b1 && b2, "R9 busy at offset 1", 128'({b0, b1, b2}), 128'(3'b111));
        if (interfere) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1;          // R8: must be ignored
            req_addr  = addr ^ 32'h0000_4440;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (b0 || b1 || b2) @(negedge clk);
        chk(p0 == 16'd20, "R2 banked penalty", 128'(p0), 128'(20));
        chk(p1 == 16'd65, "R2 narrow penalty", 128'(p1), 128'(65));
        chk(p2 == 16'd17, "R2 wide penalty", 128'(p2), 128'(17));
        chk(q0.size() + q1.size() + q2.size() == 0, "R8 missing beats",
            128'(q0.size() + q1.size() + q2.size()), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!b0 && !b1 && !b2, "R1 busy in reset", 128'({b0, b1, b2}), 128'(0));
        chk(!v0 && !v1 && !v2, "R1 valid in reset", 128'({v0, v1, v2}), 128'(0));
        chk(!l0 && !l1 && !l2, "R1 last in reset", 128'({l0, l1, l2}), 128'(0));
        chk(p0 == 0 && p1 == 0 && p2 == 0, "R1 penalty in reset",
            128'({p0, p1, p2}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        fetch(32'h0000_1200, 1'b0);
        fetch(32'h0000_05C7, 1'b0);    // R7 unaligned request
        fetch(32'h8000_0FF0, 1'b1);    // R8 request while busy
        fetch(32'hFFFF_FFFC, 1'b0);    // top block, R7
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule